// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block is the decision point between a set of 8-bit interrupt vectors and one processor. It keeps three 256-bit vectors: pending requests, vectors in service, and a per-vector trigger-mode flag. Requests arrive as a strobe with a vector number and an edge/level flag. The processor priority is formed from the task-priority register and the highest in-service vector. Priority is compared by 16-vector class, the upper nibble of the vector. The block raises its interrupt line when the highest pending vector beats that priority.

The processor acknowledges with a one-cycle strobe and receives one of three answers: a real vector (moved from pending to in service), the spurious vector (priority blocks the request), or "no interrupt". An end-of-interrupt strobe retires the highest in-service vector. For a level-triggered vector, the retirement is also announced on a broadcast strobe, unless software has chosen to suppress it.

Top module: `vec_prio_core`

## Requirements
- R1: The winning pending vector is the numerically highest set bit among the 256 request bits; a deliverable acknowledge returns it with ack_kind = 0, one cycle after ack_req.
- R2: A request strobe sets the vector's request bit. It sets the vector's trigger-mode bit when req_level = 1 and clears it when req_level = 0, so a later edge request on the same vector cancels a pending level marking.
- R3: The processor priority is the full 8-bit task priority when its upper nibble is greater than or equal to the class of the highest in-service vector. Otherwise it is that class shifted up by four. No vectors in service counts as class 0.
- R4: A pending vector is blocked when the processor priority is nonzero and the vector's upper nibble is less than or equal to the priority's upper nibble.
- R5: Acknowledging while the winner is blocked returns ack_kind = 1 with ack_vec equal to bits [7:0] of the spurious register. The request and in-service state are left unchanged.
- R6: Every ack_req produces exactly one ack_valid pulse on the next cycle. A deliverable acknowledge clears the winner's request bit and sets its in-service bit.
- R7: An EOI strobe clears only the highest in-service bit. When that vector's trigger-mode bit is set and suppression is off, eoi_bcast pulses the next cycle with eoi_vec equal to the retired vector.
- R8: With the suppression bit (bit 12 of the spurious register) set, EOI of a level vector retires it without a broadcast.
- R9: With the enable bit (bit 8 of the spurious register) clear, irq_out stays low and every acknowledge returns ack_kind = 2, "no interrupt", with ack_vec = 0.
- R10: A spurious-register write keeps bits [8:0] and bit 12 and discards all other bits. After reset the spurious vector is 0xFF and enable and suppression are clear.
- R11: irq_out is registered. It reflects, one cycle later, whether a deliverable request exists after any change to the request, in-service, task-priority or enable state. It is low after reset.
- R12: An EOI strobe while no vector is in service changes nothing and gives no broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Vector being requested |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Processor acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 8 | Task-priority write value |
| svr_we | input | 1 | Spurious-register write enable |
| svr_wdata | input | 16 | Spurious-register write value: [7:0] vector, [8] enable, [12] broadcast suppression |
| irq_out | output | 1 | Interrupt request line to the processor |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_kind | output | 2 | 0 vector, 1 spurious, 2 no interrupt |
| ack_vec | output | 8 | Acknowledged vector or spurious vector |
| eoi_bcast | output | 1 | EOI broadcast strobe |
| eoi_vec | output | 8 | Vector retired by the broadcast EOI |

## Verification
Directed sequences try the priority search on vectors spread over several 32-bit words, including both ends of the range, so a wrong word order or bit order shows up as a wrong vector. Task-priority values with the same class as the pending vector, a lower class, and a nonzero low nibble separate class-only comparison from full-byte comparison. Nested in-service vectors show whether EOI retires only the highest one. Level, edge, re-marked and suppressed vectors separate the broadcast conditions. A long pseudo-random phase then mixes requests, acknowledges, EOIs and register writes in the same cycles, and compares every output against a behavioural model on each clock.

// File: rtl/vpc_pkg.sv
// Shared types and field positions for the vectored interrupt priority core.
// Assumes 8-bit vectors; the spurious-register layout is fixed here.
package vpc_pkg;
    localparam int SVR_W       = 16;
    localparam int SVR_EN_BIT  = 8;
    localparam int SVR_DIR_BIT = 12;

    typedef enum logic [1:0] {
        ACK_VECTOR   = 2'd0,
        ACK_SPURIOUS = 2'd1,
        ACK_NONE     = 2'd2
    } ack_kind_e;
endpackage

// File: rtl/vpc_msb_find.sv
// Finds the highest set bit of a wide vector.
// Works word by word: each word finds its own top bit, then the highest
// non-empty word is chosen. Assumes N_BITS is a multiple of WORD_W and
// has at least two words.
module vpc_msb_find #(
    parameter int N_BITS = 256,
    parameter int WORD_W = 32
) (
    input  logic [N_BITS-1:0]         bits,
    output logic                      found,
    output logic [$clog2(N_BITS)-1:0] idx
);
    localparam int NWORD   = N_BITS / WORD_W;
    localparam int WPOS_W  = $clog2(WORD_W);
    localparam int WSEL_W  = $clog2(NWORD);

    logic [NWORD-1:0]        word_hit;
    logic [NWORD*WPOS_W-1:0] word_pos;

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        logic [WPOS_W-1:0] pos;

        // Top set bit inside this word (lowest wins first, higher overwrite).
        always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) pos = WPOS_W'(b);
            end
        end

        assign word_hit[w] = |bits[w*WORD_W +: WORD_W];
        assign word_pos[w*WPOS_W +: WPOS_W] = pos;
    end

    // Pick the highest word that holds any set bit.
    always_comb begin
        logic [WSEL_W-1:0] wsel;
        logic [WPOS_W-1:0] psel;
        wsel  = '0;
        psel  = '0;
        found = 1'b0;
        for (int w = 0; w < NWORD; w++) begin
            if (word_hit[w]) begin
                wsel  = WSEL_W'(w);
                psel  = word_pos[w*WPOS_W +: WPOS_W];
                found = 1'b1;
            end
        end
        idx = {wsel, psel};
    end
endmodule

// File: rtl/vpc_vec_store.sv
// Request, in-service and trigger-mode bit vectors.
// A request set wins over a same-cycle acknowledge clear of the same bit.
// An acknowledge set wins over a same-cycle EOI clear. EOI never touches
// the trigger-mode bits.
module vpc_vec_store #(
    parameter int VEC_W = 8,
    parameter int NVEC  = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             ack_take,
    input  logic [VEC_W-1:0] ack_vec,
    input  logic             eoi_take,
    input  logic [VEC_W-1:0] eoi_vec,
    output logic [NVEC-1:0]  irr,
    output logic [NVEC-1:0]  isr,
    output logic [NVEC-1:0]  tmr
);
    localparam logic [NVEC-1:0] ONE = {{(NVEC-1){1'b0}}, 1'b1};

    logic [NVEC-1:0] set_mask;
    logic [NVEC-1:0] ack_mask;
    logic [NVEC-1:0] eoi_mask;

    // One-hot masks for the three bit updates.
    always_comb begin
        set_mask = set_en   ? (ONE << set_vec) : '0;
        ack_mask = ack_take ? (ONE << ack_vec) : '0;
        eoi_mask = eoi_take ? (ONE << eoi_vec) : '0;
    end

    // Pending requests: acknowledge clears, new request sets.
    always_ff @(posedge clk) begin
        if (!rst_n) irr <= '0;
        else        irr <= (irr & ~ack_mask) | set_mask;
    end

    // In-service vectors: EOI clears, acknowledge sets.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eoi_mask) | ack_mask;
    end

    // Trigger mode follows the flag of the latest request.
    always_ff @(posedge clk) begin
        if (!rst_n)         tmr <= '0;
        else if (set_level) tmr <= tmr | set_mask;
        else                tmr <= tmr & ~set_mask;
    end
endmodule

// File: rtl/vpc_prio_gate.sv
// Processor priority and the deliver/block decision for the top pending
// vector. Classes are the upper half of the vector number. Purely
// combinational; the caller registers its outputs.
module vpc_prio_gate #(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_top,
    input  logic             sw_en,
    output logic [VEC_W-1:0] ppr,
    output logic             pend_ok,
    output logic             pend_blocked
);
    localparam int CW = VEC_W / 2;

    logic [CW-1:0] tpr_cls;
    logic [CW-1:0] isr_cls;
    logic [CW-1:0] irr_cls;
    logic          blocked;

    // Processor priority from task priority and top in-service class.
    always_comb begin
        tpr_cls = tpr[VEC_W-1 -: CW];
        isr_cls = isr_found ? isr_top[VEC_W-1 -: CW] : '0;
        ppr     = (tpr_cls >= isr_cls) ? tpr : {isr_cls, {(VEC_W-CW){1'b0}}};
    end

    // Class comparison of the top pending vector against the priority.
    always_comb begin
        irr_cls      = irr_top[VEC_W-1 -: CW];
        blocked      = irr_found && (ppr != '0) && (irr_cls <= ppr[VEC_W-1 -: CW]);
        pend_ok      = sw_en && irr_found && !blocked;
        pend_blocked = sw_en && blocked;
    end
endmodule

// File: rtl/vec_prio_core.sv
// Vectored interrupt priority core, top level.
// Holds task-priority and spurious registers, drives the registered
// interrupt line, answers acknowledges and retires vectors on EOI.
// Assumes one processor and single-cycle strobes on all inputs.
module vec_prio_core #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VEC_W-1:0]         req_vec,
    input  logic                     req_level,
    input  logic                     ack_req,
    input  logic                     eoi_req,
    input  logic                     tpr_we,
    input  logic [VEC_W-1:0]         tpr_wdata,
    input  logic                     svr_we,
    input  logic [vpc_pkg::SVR_W-1:0] svr_wdata,
    output logic                     irq_out,
    output logic                     ack_valid,
    output logic [1:0]               ack_kind,
    output logic [VEC_W-1:0]         ack_vec,
    output logic                     eoi_bcast,
    output logic [VEC_W-1:0]         eoi_vec
);
    import vpc_pkg::*;

    localparam int NVEC = 1 << VEC_W;

    logic [VEC_W-1:0] tpr_q;
    logic [VEC_W-1:0] svr_vec_q;
    logic             sw_en_q;
    logic             dir_eoi_q;

    logic [NVEC-1:0]  irr;
    logic [NVEC-1:0]  isr;
    logic [NVEC-1:0]  tmr;
    logic             irr_found;
    logic [VEC_W-1:0] irr_top;
    logic             isr_found;
    logic [VEC_W-1:0] isr_top;
    logic [VEC_W-1:0] ppr;
    logic             pend_ok;
    logic             pend_blocked;

    logic             ack_take;
    logic             eoi_take;
    logic             bcast_now;

    logic             irq_q;
    logic             ack_valid_q;
    ack_kind_e        ack_kind_q;
    logic [VEC_W-1:0] ack_vec_q;
    logic             eoi_bcast_q;
    logic [VEC_W-1:0] eoi_vec_q;

    vpc_vec_store #(.VEC_W(VEC_W), .NVEC(NVEC)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (req_valid),
        .set_vec   (req_vec),
        .set_level (req_level),
        .ack_take  (ack_take),
        .ack_vec   (irr_top),
        .eoi_take  (eoi_take),
        .eoi_vec   (isr_top),
        .irr       (irr),
        .isr       (isr),
        .tmr       (tmr)
    );

    vpc_msb_find #(.N_BITS(NVEC), .WORD_W(WORD_W)) u_irr_find (
        .bits  (irr),
        .found (irr_found),
        .idx   (irr_top)
    );

    vpc_msb_find #(.N_BITS(NVEC), .WORD_W(WORD_W)) u_isr_find (
        .bits  (isr),
        .found (isr_found),
        .idx   (isr_top)
    );

    vpc_prio_gate #(.VEC_W(VEC_W)) u_gate (
        .tpr          (tpr_q),
        .isr_found    (isr_found),
        .isr_top      (isr_top),
        .irr_found    (irr_found),
        .irr_top      (irr_top),
        .sw_en        (sw_en_q),
        .ppr          (ppr),
        .pend_ok      (pend_ok),
        .pend_blocked (pend_blocked)
    );

    // Strobe qualification for state moves and the broadcast.
    always_comb begin
        ack_take  = ack_req && pend_ok;
        eoi_take  = eoi_req && isr_found;
        bcast_now = eoi_take && tmr[isr_top] && !dir_eoi_q;
    end

    // Task-priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_q <= '0;
        else if (tpr_we) tpr_q <= tpr_wdata;
    end

    // Spurious register: vector, enable and broadcast suppression fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svr_vec_q <= '1;
            sw_en_q   <= 1'b0;
            dir_eoi_q <= 1'b0;
        end else if (svr_we) begin
            svr_vec_q <= svr_wdata[VEC_W-1:0];
            sw_en_q   <= svr_wdata[SVR_EN_BIT];
            dir_eoi_q <= svr_wdata[SVR_DIR_BIT];
        end
    end

    // Registered interrupt line from the current deliverability.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_ok;
    end

    // Acknowledge answer: vector, spurious or none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid_q <= 1'b0;
            ack_kind_q  <= ACK_NONE;
            ack_vec_q   <= '0;
        end else begin
            ack_valid_q <= ack_req;
            if (ack_req) begin
                if (pend_ok) begin
                    ack_kind_q <= ACK_VECTOR;
                    ack_vec_q  <= irr_top;
                end else if (pend_blocked) begin
                    ack_kind_q <= ACK_SPURIOUS;
                    ack_vec_q  <= svr_vec_q;
                end else begin
                    ack_kind_q <= ACK_NONE;
                    ack_vec_q  <= '0;
                end
            end
        end
    end

    // EOI broadcast strobe and the retired vector it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast_q <= 1'b0;
            eoi_vec_q   <= '0;
        end else begin
            eoi_bcast_q <= bcast_now;
            if (eoi_take) eoi_vec_q <= isr_top;
        end
    end

    assign irq_out   = irq_q;
    assign ack_valid = ack_valid_q;
    assign ack_kind  = ack_kind_q;
    assign ack_vec   = ack_vec_q;
    assign eoi_bcast = eoi_bcast_q;
    assign eoi_vec   = eoi_vec_q;
endmodule

// File: rtl/vec_prio_core_chk.sv
// Assertion checker for vec_prio_core, attached by bind below.
// Observes ports plus the enable, suppression, priority and vector state.
module vec_prio_core_chk #(
    parameter int VEC_W = 8,
    parameter int NVEC  = 1 << VEC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_req,
    input logic             irq_out,
    input logic             ack_valid,
    input logic [1:0]       ack_kind,
    input logic [VEC_W-1:0] ack_vec,
    input logic             eoi_bcast,
    input logic             sw_en,
    input logic             dir_eoi,
    input logic             irr_any,
    input logic [VEC_W-1:0] ppr,
    input logic [NVEC-1:0]  isr_vec
);
    localparam int CW = VEC_W / 2;

    assert_ack_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);

    assert_ack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_valid);

    assert_moved_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == 2'd0) |-> isr_vec[ack_vec]);

    assert_class_above_ppr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == 2'd0) |->
            ($past(ppr) == '0 || ack_vec[VEC_W-1 -: CW] > $past(ppr[VEC_W-1 -: CW])));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> !irq_out);

    assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(irr_any));

    assert_no_bcast_suppressed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(!dir_eoi));
endmodule

bind vec_prio_core vec_prio_core_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_req   (ack_req),
    .irq_out   (irq_out),
    .ack_valid (ack_valid),
    .ack_kind  (ack_kind),
    .ack_vec   (ack_vec),
    .eoi_bcast (eoi_bcast),
    .sw_en     (sw_en_q),
    .dir_eoi   (dir_eoi_q),
    .irr_any   (irr_found),
    .ppr       (ppr),
    .isr_vec   (isr)
);

// File: tb/vec_prio_core_bench.sv
// Bench for vec_prio_core: directed scenarios with literal expectations,
// plus a behavioural model compared on every clock during all phases.
module vec_prio_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        req_level = 1'b0;
    logic        ack_req = 1'b0;
    logic        eoi_req = 1'b0;
    logic        tpr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        svr_we = 1'b0;
    logic [15:0] svr_wdata = '0;
    logic        irq_out;
    logic        ack_valid;
    logic [1:0]  ack_kind;
    logic [7:0]  ack_vec;
    logic        eoi_bcast;
    logic [7:0]  eoi_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vec_prio_core u_vec_prio_core (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
        .ack_req(ack_req), .eoi_req(eoi_req),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .svr_we(svr_we), .svr_wdata(svr_wdata),
        .irq_out(irq_out), .ack_valid(ack_valid), .ack_kind(ack_kind),
        .ack_vec(ack_vec), .eoi_bcast(eoi_bcast), .eoi_vec(eoi_vec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    bit [255:0] m_irr, m_isr, m_tmr;
    int m_tpr, m_svr_vec;
    bit m_en, m_dir;
    bit m_irq, m_ackv, m_bc;
    int m_kind, m_ackvec, m_bcvec;

    function automatic int top_of(input bit [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        int ih, sh, icls, p;
        bit blk, ok;
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_tmr = '0;
            m_tpr = 0; m_svr_vec = 8'hFF; m_en = 0; m_dir = 0;
            m_irq = 0; m_ackv = 0; m_bc = 0; m_kind = 2; m_ackvec = 0; m_bcvec = 0;
        end else begin
            ih   = top_of(m_irr);
            sh   = top_of(m_isr);
            icls = (sh < 0) ? 0 : sh / 16;
            p    = ((m_tpr / 16) >= icls) ? m_tpr : icls * 16;
            blk  = (ih >= 0) && (p != 0) && ((ih / 16) <= (p / 16));
            ok   = m_en && (ih >= 0) && !blk;
            m_irq  = ok;
            m_ackv = ack_req;
            m_bc   = 0;
            if (eoi_req && sh >= 0) begin
                m_isr[sh] = 1'b0;
                m_bcvec   = sh;
                m_bc      = m_tmr[sh] && !m_dir;
            end
            if (ack_req) begin
                if (ok) begin
                    m_kind = 0; m_ackvec = ih;
                    m_irr[ih] = 1'b0; m_isr[ih] = 1'b1;
                end else if (m_en && blk) begin
                    m_kind = 1; m_ackvec = m_svr_vec;
                end else begin
                    m_kind = 2; m_ackvec = 0;
                end
            end
            if (req_valid) begin
                m_irr[req_vec] = 1'b1;
                m_tmr[req_vec] = req_level;
            end
            if (tpr_we) m_tpr = tpr_wdata;
            if (svr_we) begin
                m_svr_vec = svr_wdata[7:0];
                m_en      = svr_wdata[8];
                m_dir     = svr_wdata[12];
            end
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(irq_out == m_irq, "R11 irq_out vs model", irq_out, m_irq);
            chk(ack_valid == m_ackv, "R6 ack_valid vs model", ack_valid, m_ackv);
            if (ack_valid && m_ackv) begin
                chk(ack_kind == m_kind[1:0], "R5/R9 ack_kind vs model", ack_kind, m_kind);
                chk(ack_vec == m_ackvec[7:0], "R1 ack_vec vs model", ack_vec, m_ackvec);
            end
            chk(eoi_bcast == m_bc, "R7 eoi_bcast vs model", eoi_bcast, m_bc);
            if (eoi_bcast && m_bc)
                chk(eoi_vec == m_bcvec[7:0], "R7 eoi_vec vs model", eoi_vec, m_bcvec);
        end
    end

    // ---------------- stimulus tasks (called at a negedge) ----------------
    task automatic set_req(input logic [7:0] v, input bit lvl);
        req_valid = 1; req_vec = v; req_level = lvl;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        tpr_we = 1; tpr_wdata = v;
        @(negedge clk);
        tpr_we = 0;
    endtask

    task automatic wr_svr(input logic [15:0] v);
        svr_we = 1; svr_wdata = v;
        @(negedge clk);
        svr_we = 0;
    endtask

    task automatic do_ack(input int kind, input int vec, input string tag);
        ack_req = 1;
        @(negedge clk);
        ack_req = 0;
        chk(ack_valid == 1'b1, tag, ack_valid, 1);
        chk(ack_kind == kind[1:0], tag, ack_kind, kind);
        chk(ack_vec == vec[7:0], tag, ack_vec, vec);
    endtask

    task automatic do_eoi(input bit bc, input int vec, input string tag);
        eoi_req = 1;
        @(negedge clk);
        eoi_req = 0;
        chk(eoi_bcast == bc, tag, eoi_bcast, bc);
        if (bc) chk(eoi_vec == vec[7:0], tag, eoi_vec, vec);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: line low after reset
        chk(irq_out == 1'b0, "R11 reset irq", irq_out, 0);
        // R9 / R10: reset leaves the core disabled
        do_ack(2, 0, "R9 ack while disabled after reset");

        // R10: junk in discarded bits; vector FF, enable on, suppression off
        wr_svr(16'hE1FF);
        set_req(8'h45, 0);
        chk(irq_out == 1'b0, "R11 irq one cycle late", irq_out, 0);
        @(negedge clk);
        chk(irq_out == 1'b1, "R11 irq raised", irq_out, 1);

        // R1: highest across words
        set_req(8'h20, 0); set_req(8'h9F, 0); set_req(8'h31, 0);
        do_ack(0, 8'h9F, "R1 highest pending");
        do_ack(1, 8'hFF, "R4/R5 blocked by in-service class");
        do_ack(1, 8'hFF, "R5 state unchanged after spurious");
        do_eoi(0, 0, "R7 edge vector no broadcast");
        do_ack(0, 8'h45, "R6 next vector delivered");

        // R3: task priority against in-service class
        do_eoi(0, 0, "R7 retire 45");
        wr_tpr(8'h3F);
        do_ack(1, 8'hFF, "R3 equal class blocked");
        wr_tpr(8'h2F);
        do_ack(0, 8'h31, "R3 class above low nibble delivered");
        wr_tpr(8'h00);
        do_ack(1, 8'hFF, "R3 in-service class dominates tpr");
        do_eoi(0, 0, "R7 retire 31");
        do_ack(0, 8'h20, "R3 empty in-service and zero tpr");
        do_eoi(0, 0, "R7 retire 20");

        // R12: EOI with nothing in service
        do_eoi(0, 0, "R12 empty eoi no broadcast");
        do_ack(2, 0, "R12 nothing pending after empty eoi");

        // R7: level broadcast
        set_req(8'hC8, 1);
        do_ack(0, 8'hC8, "R7 ack level vector");
        do_eoi(1, 8'hC8, "R7 level broadcast");

        // R2: edge re-marks a level vector
        set_req(8'hD0, 1); set_req(8'hD0, 0);
        do_ack(0, 8'hD0, "R2 ack remarked vector");
        do_eoi(0, 0, "R2 edge remark clears trigger");

        // R8: suppression
        wr_svr(16'h11FF);
        set_req(8'hE0, 1);
        do_ack(0, 8'hE0, "R8 ack level vector");
        do_eoi(0, 0, "R8 suppressed broadcast");
        wr_svr(16'h01FF);

        // R7: nested, only highest retired
        set_req(8'h50, 1);
        do_ack(0, 8'h50, "R7 nested outer");
        set_req(8'h70, 1);
        do_ack(0, 8'h70, "R7 nested inner");
        do_eoi(1, 8'h70, "R7 retire highest first");
        do_eoi(1, 8'h50, "R7 retire outer");

        // R1: range ends
        set_req(8'h01, 0); set_req(8'hFF, 0);
        do_ack(0, 8'hFF, "R1 top vector");
        do_ack(1, 8'hFF, "R4 class 0 under class F");
        do_eoi(0, 0, "R7 retire FF");
        do_ack(0, 8'h01, "R1 bottom word vector");
        do_eoi(0, 0, "R7 retire 01");

        // R9: disable hides a pending request
        set_req(8'h60, 0);
        wr_svr(16'h00AA);
        @(negedge clk);
        chk(irq_out == 1'b0, "R9 irq low while disabled", irq_out, 0);
        do_ack(2, 0, "R9 ack none while disabled");
        wr_svr(16'h01AA);
        @(negedge clk);
        chk(irq_out == 1'b1, "R11 irq back after enable", irq_out, 1);
        wr_tpr(8'h70);
        do_ack(1, 8'hAA, "R5 spurious vector from register");
        wr_tpr(8'h00);
        do_ack(0, 8'h60, "R6 delivered after enable");
        do_eoi(0, 0, "R7 retire 60");

        // Mixed pseudo-random phase, compared against the model each clock.
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            req_valid = lfsr[2] & lfsr[5];
            req_vec   = lfsr[15:8];
            req_level = lfsr[16];
            ack_req   = lfsr[17] & lfsr[18];
            eoi_req   = lfsr[19] & lfsr[20] & lfsr[21];
            tpr_we    = (lfsr[27:22] == 6'd0);
            tpr_wdata = {lfsr[31:29], 5'd0};
            svr_we    = (lfsr[28:23] == 6'd5);
            svr_wdata = {3'b000, lfsr[3], 3'b000, (lfsr[4] | lfsr[6]), lfsr[31:24]};
            @(negedge clk);
        end
        req_valid = 0; ack_req = 0; eoi_req = 0; tpr_we = 0; svr_we = 0;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule